// File: doc/BRIEF.md
# Grouped-Priority Nested Interrupt Arbiter

This block decides which interrupt request a processor core should take next, and when. It watches a set of maskable request lines, each with its own enable bit and a 4-bit urgency value, where a smaller value is more urgent. A global grouping code splits every urgency value into an upper nesting field and a lower ordering field. Only the nesting field decides whether a request may interrupt work already in progress. The ordering field only breaks ties among requests that wait together.

Two fixed exceptions sit above every maskable level: a non-maskable request and a hard-fault request. The non-maskable request outranks the hard fault. A light global mask blocks all maskable requests. A heavy global mask also blocks the hard fault, which leaves only the non-maskable request. The arbiter keeps a stack of the levels now in service. Each accepted request pushes its level, and a completion strobe pops the top level. Acceptance is signalled by a one-cycle registered strobe that carries the kind of request and, for a maskable one, its line index.

Top module: `irq_grp_arbiter`

## Requirements
- R1: After reset no take strobe is raised, nothing is pending and the active level output reads all ones (idle, 31 with default widths).
- R2: A maskable line becomes pending on a rising edge only, so a level held high is taken once. A pending line whose enable bit is low stays pending and cannot win, and it is taken later once its enable bit goes high.
- R3: Grouping codes 7, 6, 5, 4 and 3 give 0, 1, 2, 3 and 4 upper urgency bits to the nesting field. Codes 0 to 2 behave like code 3.
- R4: Among enabled pending maskable lines, the winner has the smallest full 4-bit urgency value: the nesting field is compared first, then the ordering field. Equal values go to the lowest line index.
- R5: A maskable winner is taken only when its nesting field is strictly more urgent than the level at the top of the active stack, or when the stack is empty.
- R6: A pending request whose nesting field equals the active one waits until that level completes, however urgent its ordering field is.
- R7: The non-maskable request (active level 0) outranks the hard fault (level 1), and both outrank every maskable request. A maskable request is recorded as level (urgency with the ordering bits cleared) + 2.
- R8: While the light mask is high, no maskable request is taken, but the hard fault and the non-maskable request are still taken.
- R9: While the heavy mask is high, only the non-maskable request is taken.
- R10: A completion strobe pops the top active level and restores the one below it, or idle when the stack empties. A completion strobe with an empty stack has no effect.
- R11: The take strobe lasts one cycle and appears the cycle after the decision. Its kind code is 0 for maskable, 1 for hard fault and 2 for non-maskable, and its index is 0 unless the kind is maskable. No request is taken in a cycle in which the completion strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | NSRC | Maskable request lines, rising-edge sensitive |
| en_i | input | NSRC | Per-line enable bits |
| prio_i | input | NSRC*PRIO_W | Urgency value per line, line k at bits k*PRIO_W upward |
| grp_code_i | input | 3 | Grouping code |
| nmi_i | input | 1 | Non-maskable request, rising-edge sensitive |
| hflt_i | input | 1 | Hard-fault request, rising-edge sensitive |
| pmask_i | input | 1 | Light global mask |
| fmask_i | input | 1 | Heavy global mask |
| done_i | input | 1 | Completion strobe for the level at the top of the stack |
| take_o | output | 1 | One-cycle take strobe |
| take_kind_o | output | 2 | Kind of the taken request |
| take_idx_o | output | IDX_W | Index of the taken maskable line |
| act_lvl_o | output | LVL_W | Level at the top of the active stack, all ones when idle |

## Verification
A wrong pending bit shows up as a missed take or an extra take. It is visible two cycles after the request edge that should or should not have armed it. A stack entry that is wrong or lost shows on the active level output in the cycle after the push or pop. It also shows as a nesting decision that differs from the model the next time a request arrives at a level near it. The bench runs a cycle-accurate model built from the requirements and compares the take strobe, its kind and index, and the active level at every cycle. A fault therefore surfaces at the first cycle on which it has any effect on the ports.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      KIND_IRQ = 2'd0,
      KIND_HF  = 2'd1,
      KIND_NMI = 2'd2
   } take_kind_e;

   localparam int unsigned LVL_NMI  = 0;
   localparam int unsigned LVL_HF   = 1;
   localparam int unsigned LVL_BASE = 2;

   // Number of nesting bits selected by a grouping code.
   function automatic int unsigned nest_bits(input logic [2:0] code, input int unsigned maxg);
      int unsigned g;
      if (code >= 3'd3) g = 32'(3'd7 - code);
      else              g = maxg;
      if (g > maxg) g = maxg;
      return g;
   endfunction

endpackage

// File: rtl/irq_edge_latch.sv
module irq_edge_latch #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] lvl_i,
   input  logic [W-1:0] clr_i,
   output logic [W-1:0] pend_o
);

   logic [W-1:0] prev_q;

   for (genvar k = 0; k < W; k++) begin : g_bit
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            prev_q[k] <= 1'b0;
            pend_o[k] <= 1'b0;
         end else begin
            prev_q[k] <= lvl_i[k];
            pend_o[k] <= (pend_o[k] & ~clr_i[k]) | (lvl_i[k] & ~prev_q[k]);
         end
      end
   end

endmodule

// File: rtl/irq_pick.sv
module irq_pick #(
   parameter int NSRC   = 8,
   parameter int PRIO_W = 4,
   parameter int IDX_W  = 3
) (
   input  logic [NSRC-1:0]        cand_i,
   input  logic [NSRC*PRIO_W-1:0] prio_i,
   output logic                   valid_o,
   output logic [IDX_W-1:0]       idx_o,
   output logic [PRIO_W-1:0]      prio_o
);

   generate
      if (NSRC == 1) begin : g_single
         assign valid_o = cand_i[0];
         assign idx_o   = '0;
         assign prio_o  = prio_i[PRIO_W-1:0];
      end else begin : g_multi
         always_comb begin
            valid_o = 1'b0;
            idx_o   = '0;
            prio_o  = '1;
            for (int i = 0; i < NSRC; i++) begin
               if (cand_i[i] && (!valid_o || (prio_i[i*PRIO_W +: PRIO_W] < prio_o))) begin
                  valid_o = 1'b1;
                  idx_o   = IDX_W'(i);
                  prio_o  = prio_i[i*PRIO_W +: PRIO_W];
               end
            end
         end
      end
   endgenerate

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack #(
   parameter int DEPTH = 18,
   parameter int LVL_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             push_i,
   input  logic             pop_i,
   input  logic [LVL_W-1:0] lvl_i,
   output logic [LVL_W-1:0] top_o
);

   localparam int CNT_W = $clog2(DEPTH + 1);

   logic [LVL_W-1:0] mem [DEPTH];
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (pop_i) begin
         if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
      end else if (push_i && (32'(cnt_q) < DEPTH)) begin
         mem[cnt_q] <= lvl_i;
         cnt_q      <= cnt_q + 1'b1;
      end
   end

   assign top_o = (cnt_q == '0) ? '1 : mem[cnt_q - 1'b1];

endmodule

// File: rtl/irq_grp_arbiter.sv
module irq_grp_arbiter
   import irq_arb_pkg::*;
#(
   parameter int  NSRC   = 8,
   parameter int  PRIO_W = 4,
   localparam int IDX_W  = (NSRC > 1) ? $clog2(NSRC) : 1,
   localparam int DEPTH  = (1 << PRIO_W) + 2,
   localparam int LVL_W  = $clog2(DEPTH + 1)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic [NSRC-1:0]        src_i,
   input  logic [NSRC-1:0]        en_i,
   input  logic [NSRC*PRIO_W-1:0] prio_i,
   input  logic [2:0]             grp_code_i,
   input  logic                   nmi_i,
   input  logic                   hflt_i,
   input  logic                   pmask_i,
   input  logic                   fmask_i,
   input  logic                   done_i,
   output logic                   take_o,
   output logic [1:0]             take_kind_o,
   output logic [IDX_W-1:0]       take_idx_o,
   output logic [LVL_W-1:0]       act_lvl_o
);

   generate
      if (NSRC < 1)   begin : g_bad_nsrc $error("NSRC must be at least 1"); end
      if (PRIO_W != 4) begin : g_bad_pw   $error("grouping codes assume a 4-bit urgency value"); end
   endgenerate

   localparam logic [LVL_W-1:0] IDLE = '1;

   logic [NSRC-1:0]   irq_pend, irq_clr;
   logic [1:0]        fix_pend, fix_clr;
   logic              win_v;
   logic [IDX_W-1:0]  win_idx;
   logic [PRIO_W-1:0] win_prio, nest_mask;
   logic [LVL_W-1:0]  win_lvl, top_lvl, push_lvl;
   logic              go_nmi, go_hf, go_irq, go_any;

   // Pending latches: maskable lines, then {nmi, hard fault}.
   irq_edge_latch #(.W(NSRC)) u_irq_pend (
      .clk(clk), .rst_n(rst_n), .lvl_i(src_i), .clr_i(irq_clr), .pend_o(irq_pend)
   );

   irq_edge_latch #(.W(2)) u_fix_pend (
      .clk(clk), .rst_n(rst_n), .lvl_i({nmi_i, hflt_i}), .clr_i(fix_clr), .pend_o(fix_pend)
   );

   // Winner among enabled pending lines, smallest full urgency value.
   irq_pick #(.NSRC(NSRC), .PRIO_W(PRIO_W), .IDX_W(IDX_W)) u_pick (
      .cand_i(irq_pend & en_i), .prio_i(prio_i),
      .valid_o(win_v), .idx_o(win_idx), .prio_o(win_prio)
   );

   // Grouping decode: upper bits form the nesting field.
   always_comb begin
      int unsigned nb;
      nb = nest_bits(grp_code_i, PRIO_W);
      nest_mask = '0;
      for (int b = 0; b < PRIO_W; b++) begin
         if (b >= (PRIO_W - int'(nb))) nest_mask[b] = 1'b1;
      end
   end

   assign win_lvl = LVL_W'(win_prio & nest_mask) + LVL_W'(LVL_BASE);

   // Preemption decision against the active top level.
   assign go_nmi = fix_pend[1] && !done_i && (top_lvl != LVL_W'(LVL_NMI));
   assign go_hf  = !go_nmi && fix_pend[0] && !fmask_i && !done_i
                   && (top_lvl > LVL_W'(LVL_HF));
   assign go_irq = !go_nmi && !go_hf && win_v && !pmask_i && !fmask_i && !done_i
                   && (win_lvl < top_lvl);
   assign go_any = go_nmi | go_hf | go_irq;

   always_comb begin
      irq_clr = '0;
      if (go_irq) irq_clr[win_idx] = 1'b1;
   end
   assign fix_clr = {go_nmi, go_hf};

   assign push_lvl = go_nmi ? LVL_W'(LVL_NMI) :
                     go_hf  ? LVL_W'(LVL_HF)  : win_lvl;

   irq_lvl_stack #(.DEPTH(DEPTH), .LVL_W(LVL_W)) u_stack (
      .clk(clk), .rst_n(rst_n), .push_i(go_any), .pop_i(done_i),
      .lvl_i(push_lvl), .top_o(top_lvl)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         take_o      <= 1'b0;
         take_kind_o <= KIND_IRQ;
         take_idx_o  <= '0;
      end else begin
         take_o      <= go_any;
         take_kind_o <= go_nmi ? KIND_NMI : (go_hf ? KIND_HF : KIND_IRQ);
         take_idx_o  <= go_irq ? win_idx : '0;
      end
   end

   assign act_lvl_o = (top_lvl == IDLE) ? IDLE : top_lvl;

endmodule

// File: rtl/irq_grp_arbiter_chk.sv
module irq_grp_arbiter_chk #(
   parameter int NSRC  = 8,
   parameter int IDX_W = 3,
   parameter int LVL_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic [NSRC-1:0]  en_i,
   input logic             pmask_i,
   input logic             fmask_i,
   input logic             done_i,
   input logic             take_o,
   input logic [1:0]       take_kind_o,
   input logic [IDX_W-1:0] take_idx_o,
   input logic [LVL_W-1:0] act_lvl_o
);

   AST_TAKE_NESTS: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (act_lvl_o < $past(act_lvl_o)));                               // R5
   AST_IRQ_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && take_kind_o == 2'd0) |-> (!$past(pmask_i) && !$past(fmask_i))); // R8
   AST_HF_UNMASKED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && take_kind_o == 2'd1) |-> !$past(fmask_i));                     // R9
   AST_NO_TAKE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> !$past(done_i));                                               // R11
   AST_WINNER_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && take_kind_o == 2'd0)
         |-> ((($past(en_i) >> take_idx_o) & NSRC'(1)) != '0));                 // R2
   AST_KIND_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
      take_o |-> (take_kind_o != 2'd3));                                        // R11
   AST_FIXED_LEVELS: assert property (@(posedge clk) disable iff (!rst_n)
      (take_o && take_kind_o == 2'd2) |-> (act_lvl_o == '0));                   // R7

endmodule

bind irq_grp_arbiter irq_grp_arbiter_chk #(.NSRC(NSRC), .IDX_W(IDX_W), .LVL_W(LVL_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .en_i(en_i), .pmask_i(pmask_i), .fmask_i(fmask_i),
   .done_i(done_i), .take_o(take_o), .take_kind_o(take_kind_o),
   .take_idx_o(take_idx_o), .act_lvl_o(act_lvl_o)
);

// File: tb/irq_grp_arbiter_tb_top.sv
module irq_grp_arbiter_tb_top;

   localparam int N = 8, PW = 4, IW = 3, LW = 5, IDLE = 31;

   logic          clk = 1'b0, rst_n = 1'b0;
   logic [N-1:0]  src = '0, en = '0;
   logic [N*PW-1:0] prio = '0;
   logic [2:0]    gcode = 3'd3;
   logic          nmi = 1'b0, hf = 1'b0, pm = 1'b0, fm = 1'b0, done = 1'b0;
   logic          take_o;
   logic [1:0]    take_kind_o;
   logic [IW-1:0] take_idx_o;
   logic [LW-1:0] act_lvl_o;

   int total = 0, bad = 0;
   string cur_req = "R1";
   bit finished = 0;

   always #5 clk = ~clk;

   irq_grp_arbiter #(.NSRC(N), .PRIO_W(PW)) dut_i (
      .clk(clk), .rst_n(rst_n), .src_i(src), .en_i(en), .prio_i(prio),
      .grp_code_i(gcode), .nmi_i(nmi), .hflt_i(hf), .pmask_i(pm), .fmask_i(fm),
      .done_i(done), .take_o(take_o), .take_kind_o(take_kind_o),
      .take_idx_o(take_idx_o), .act_lvl_o(act_lvl_o)
   );

   // ---------------- reference model ----------------
   bit m_pend[N], m_prev[N];
   bit m_np, m_hp, m_nq, m_hq;
   int stk[32];
   int sp;
   int m_take, m_kind, m_idx;

   function automatic int grp_of(input logic [2:0] c);
      return (c >= 3) ? 7 - int'(c) : 4;
   endfunction

   function automatic int lvl_of(input int p, input logic [2:0] c);
      int sb;
      sb = 4 - grp_of(c);
      return ((p >> sb) << sb) + 2;
   endfunction

   function automatic int m_top();
      return (sp == 0) ? IDLE : stk[sp-1];
   endfunction

   task automatic model_reset();
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_prev[i] = 0; end
      m_np = 0; m_hp = 0; m_nq = 0; m_hq = 0; sp = 0;
      m_take = 0; m_kind = 0; m_idx = 0;
   endtask

   task automatic model_step();
      int top, best, bp, p;
      bit gn, gh, gi;
      top = m_top();
      best = -1; bp = 99;
      for (int i = 0; i < N; i++) begin
         p = int'(prio[i*PW +: PW]);
         if (m_pend[i] && en[i] && p < bp) begin best = i; bp = p; end
      end
      gn = m_np && !done && top != 0;
      gh = !gn && m_hp && !fm && !done && top > 1;
      gi = !gn && !gh && best >= 0 && !pm && !fm && !done && lvl_of(bp, gcode) < top;
      m_take = (gn || gh || gi) ? 1 : 0;
      m_kind = gn ? 2 : (gh ? 1 : 0);
      m_idx  = gi ? best : 0;
      if (done) begin
         if (sp > 0) sp--;
      end else if (m_take != 0) begin
         stk[sp] = gn ? 0 : (gh ? 1 : lvl_of(bp, gcode));
         sp++;
      end
      if (gi) m_pend[best] = 0;
      if (gn) m_np = 0;
      if (gh) m_hp = 0;
      for (int i = 0; i < N; i++) begin
         if (src[i] && !m_prev[i]) m_pend[i] = 1;
         m_prev[i] = src[i];
      end
      if (nmi && !m_nq) m_np = 1;
      if (hf && !m_hq) m_hp = 1;
      m_nq = nmi; m_hq = hf;
   endtask

   always @(posedge clk) begin
      if (!rst_n) model_reset();
      else        model_step();
   end

   // ---------------- checking ----------------
   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n && !finished) begin
         chk(int'(take_o) == m_take, cur_req, int'(take_o), m_take);
         if (m_take != 0) begin
            chk(int'(take_kind_o) == m_kind, cur_req, int'(take_kind_o), m_kind);
            chk(int'(take_idx_o) == m_idx, cur_req, int'(take_idx_o), m_idx);
         end
         chk(int'(act_lvl_o) == m_top(), "R10", int'(act_lvl_o), m_top());
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 0; src = '0; en = '0; prio = '0; nmi = 0; hf = 0;
      pm = 0; fm = 0; done = 0; gcode = 3'd3;
      tick(2);
      rst_n = 1;
      tick(1);
   endtask

   task automatic setp(input int i, input int p);
      prio[i*PW +: PW] = PW'(p);
   endtask

   task automatic pulse(input int i);
      src[i] = 1; tick(1); src[i] = 0;
   endtask

   task automatic fin();
      tick(1); done = 1; tick(1); done = 0;
   endtask

   // ---------------- scenarios ----------------
   initial begin
      cur_req = "R1";
      do_reset();
      chk(take_o == 1'b0, "R1", int'(take_o), 0);
      chk(int'(act_lvl_o) == IDLE, "R1", int'(act_lvl_o), IDLE);
      tick(3);

      // R2: held level taken once; disabled line stays pending
      cur_req = "R2";
      do_reset(); en = '1; en[3] = 0; setp(0, 5); setp(3, 2);
      src[0] = 1; tick(8); fin(); tick(3);
      pulse(3); tick(5);
      chk(int'(act_lvl_o) == IDLE, "R2", int'(act_lvl_o), IDLE);
      en[3] = 1; tick(1);
      chk(take_o && take_idx_o == 3'd3, "R2", int'(take_idx_o), 3);
      src[0] = 0; tick(3);

      // R3: code 7 => no nesting, code 3 => full nesting, code 1 like code 3
      cur_req = "R3";
      do_reset(); en = '1; gcode = 3'd7; setp(0, 9); setp(1, 0);
      pulse(0); tick(2); pulse(1); tick(4);
      chk(int'(act_lvl_o) == 2, "R3", int'(act_lvl_o), 2);
      do_reset(); en = '1; gcode = 3'd3; setp(0, 9); setp(1, 0);
      pulse(0); tick(2); pulse(1); tick(4);
      chk(int'(act_lvl_o) == 2, "R3", int'(act_lvl_o), 2);
      do_reset(); en = '1; gcode = 3'd1; setp(0, 9); setp(1, 4);
      pulse(0); tick(2); pulse(1); tick(4);
      chk(int'(act_lvl_o) == 6, "R3", int'(act_lvl_o), 6);

      // R4: simultaneous requests, tie on value goes to low index
      cur_req = "R4";
      do_reset(); en = '1; setp(5, 3); setp(2, 3); setp(6, 7);
      src[5] = 1; src[2] = 1; src[6] = 1; tick(1); src = '0; tick(1);
      chk(take_o && take_idx_o == 3'd2, "R4", int'(take_idx_o), 2);
      fin(); fin(); fin(); tick(3);

      // R5 / R6: group 2 (code 5): 0111 active, 0100 waits, 0011 nests
      cur_req = "R6";
      do_reset(); en = '1; gcode = 3'd5; setp(0, 7); setp(1, 4); setp(2, 3);
      pulse(0); tick(2); pulse(1); tick(4);
      chk(int'(act_lvl_o) == 6, "R6", int'(act_lvl_o), 6);
      cur_req = "R5";
      pulse(2); tick(1);
      chk(take_o && take_idx_o == 3'd2, "R5", int'(take_idx_o), 2);
      fin(); cur_req = "R6"; fin(); tick(2);
      chk(int'(act_lvl_o) == 6, "R6", int'(act_lvl_o), 6);
      fin(); tick(3);

      // R7: nmi over hard fault over maskable
      cur_req = "R7";
      do_reset(); en = '1; setp(4, 0);
      src[4] = 1; nmi = 1; hf = 1; tick(1); src = '0; nmi = 0; hf = 0; tick(1);
      chk(take_o && take_kind_o == 2'd2, "R7", int'(take_kind_o), 2);
      tick(3); fin(); tick(1); fin(); tick(1); fin(); tick(3);

      // R8: light mask
      cur_req = "R8";
      do_reset(); en = '1; pm = 1; setp(1, 1);
      pulse(1); tick(4); hf = 1; tick(1); hf = 0; tick(3);
      chk(int'(act_lvl_o) == 1, "R8", int'(act_lvl_o), 1);
      fin(); tick(3); pm = 0; tick(3); fin(); tick(2);

      // R9: heavy mask
      cur_req = "R9";
      do_reset(); en = '1; fm = 1; setp(1, 1);
      pulse(1); hf = 1; tick(1); hf = 0; tick(4);
      chk(int'(act_lvl_o) == IDLE, "R9", int'(act_lvl_o), IDLE);
      nmi = 1; tick(1); nmi = 0; tick(3);
      chk(int'(act_lvl_o) == 0, "R9", int'(act_lvl_o), 0);
      fin(); fm = 0; tick(5); fin(); fin(); tick(2);

      // R10: pops, and completion on empty stack
      cur_req = "R10";
      do_reset(); en = '1; setp(0, 8); setp(1, 4); setp(2, 0);
      pulse(0); tick(2); pulse(1); tick(2); pulse(2); tick(3);
      fin(); fin(); fin(); fin(); fin(); tick(2);
      chk(int'(act_lvl_o) == IDLE, "R10", int'(act_lvl_o), IDLE);

      // R11: completion held high blocks taking
      cur_req = "R11";
      do_reset(); en = '1; setp(3, 2);
      done = 1; pulse(3); tick(4);
      chk(take_o == 1'b0, "R11", int'(take_o), 0);
      done = 0; tick(1); tick(1);
      chk(take_o == 1'b0 && int'(act_lvl_o) == 4, "R11", int'(act_lvl_o), 4);

      // Random phase (R4 tag), fixed seed
      cur_req = "R4";
      do_reset();
      void'($urandom(32'd1234));
      for (int c = 0; c < 4000; c++) begin
         @(negedge clk);
         if ($urandom_range(0, 3) == 0) src[$urandom_range(0, N-1)] ^= 1'b1;
         if ($urandom_range(0, 15) == 0) en[$urandom_range(0, N-1)] ^= 1'b1;
         if ($urandom_range(0, 15) == 0) setp($urandom_range(0, N-1), $urandom_range(0, 15));
         if ($urandom_range(0, 63) == 0) gcode = 3'($urandom_range(0, 7));
         done = ($urandom_range(0, 5) == 0);
         nmi  = ($urandom_range(0, 60) == 0);
         hf   = ($urandom_range(0, 40) == 0);
         if ($urandom_range(0, 100) == 0) pm = ~pm;
         if ($urandom_range(0, 150) == 0) fm = ~fm;
      end
      tick(2);
      if (!finished) begin
         finished = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      #2_000_000;
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule